// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block sits between a synchronous host port and an x4 asynchronous DRAM that takes its 20-bit cell address in two halves over a shared 10-bit bus. It turns each accepted host read or write into a sequence of active-low row strobe, column strobe, write enable and output enable transitions, and it steers the direction of a 4-bit common data bus. Every minimum analog timing figure is given as a nanosecond parameter and converted to clock cycles at the configured clock period. Minimums are rounded up. The row-low maximum is rounded down.

After a cycle completes, the row stays open. A later request to the same row runs as a column-only page cycle. A request to any other row first closes the row and waits out the precharge, then opens the new row. Writes always use early-write timing: write enable falls before the column strobe, so the DRAM never drives the shared bus while the controller does. A long-open row is closed before it reaches the row-low limit. A separate refresh arbiter requests the device through a request/grant pair. The controller closes the row, waits the precharge, and grants with all strobes released.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: While reset is held, and on the first cycle after it, the row and column strobes, write enable and output enable are all high, and the data-bus drive, grant and response-valid outputs are low.
- R2: The row half is bits 19..10 of the request address. It is on the DRAM address bus in the cycle the row strobe falls and stays there for at least the row-hold cycle count.
- R3: The column half is bits 9..0 of the request address. It is on the bus when the column strobe falls and stays unchanged while the column strobe is low.
- R4: A write drives write enable low at least one cycle before the column strobe falls and drives the write data on the bus while the column strobe is low. Output enable stays high throughout.
- R5: A read holds output enable low while the column strobe is low. It returns the cell data on the read-data output with a response-valid pulse that lasts exactly one cycle, and responses come back in request order.
- R6: A request whose row equals the open row runs without any row strobe transition. The column strobe is low only while the row strobe is low.
- R7: A request to a different row raises the row strobe. The row strobe stays high for at least the precharge cycle count before it falls for the new row.
- R8: The strobes meet these minimums: row strobe low time, row strobe fall-to-fall period, row-to-column delay, column strobe low time, column strobe high time within a page, and column fall-to-fall period within a page.
- R9: Read data is captured no earlier than the row access time after the row strobe fell and no earlier than the column access time after the column strobe fell.
- R10: The row strobe never stays low for more cycles than the row-low maximum.
- R11: Once refresh is requested, the grant rises within a bounded number of cycles with both strobes high. While the grant is high, host requests are not accepted and the strobes stay high. After the request drops, host traffic resumes.
- R12: The controller drives the data bus only while write enable is low and output enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted on this clock edge when valid is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Cell address; row half in 19..10, column half in 9..0 |
| req_wdata | input | 4 | Write data |
| rsp_valid | output | 1 | One-cycle pulse carrying read data |
| rsp_rdata | output | 4 | Read data |
| ref_req | input | 1 | Refresh arbiter asks for the device |
| ref_gnt | output | 1 | Device handed to the refresh arbiter, strobes released |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dq_out | output | 4 | Data driven toward the DRAM |
| dq_oe | output | 1 | Drive enable for dq_out |
| dq_in | input | 4 | Data received from the DRAM |

## Verification
On every cycle, the embedded assertions check the following: strobe nesting, bus direction against write and output enable, write enable leading the column strobe, column address stability, the row-low minimum and maximum, the quiet strobes under grant, and the bound on refresh wait. Only the bench scenarios can show the rest. These are that data written in page bursts comes back from the right cells, and that hits and misses produce the expected count of row openings. They also show that reads sample late enough to avoid the model's poisoned early data, and that requests held during a grant are not accepted and complete afterwards.

// File: rtl/fpm_pkg.sv
// Shared types and helpers for the page-mode DRAM controller.
// Assumes all timing figures are positive integers.
package fpm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,    // row closed, precharging or waiting
        ST_ROW,     // row strobe low, waiting row-to-column delay
        ST_COLSET,  // page hit: column address and write enable settle
        ST_CAS,     // column strobe low
        ST_CP,      // column strobe precharge inside the page
        ST_OPEN,    // row open, column strobe high, waiting
        ST_CLOSE,   // row closing, waiting row-low minimum
        ST_REF      // device handed to refresh arbiter
    } fpm_state_e;

    // Integer division rounded up, never below one.
    function automatic int ns_to_cyc_up(input int ns, input int clk_ns);
        int r;
        r = (ns + clk_ns - 1) / clk_ns;
        return (r < 1) ? 1 : r;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fpm_timer.sv
// Down-counter used to enforce one timing minimum.
// Loading V makes done rise V cycles later; done is high from reset.
module fpm_timer #(
    parameter int MAXV = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load,
    input  logic [$clog2(MAXV+1)-1:0]    load_val,
    output logic                         done
);

    logic [$clog2(MAXV+1)-1:0] cnt;

    // Count down to zero, reload on request.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (load)           cnt <= load_val;
        else if (cnt != '0)      cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

    // R8: an expired timer stays expired until reloaded.
    a_r8_timer_holds_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load) |=> done);

endmodule

// File: rtl/fpm_row_track.sv
// Remembers which row is open and compares incoming rows against it.
// Assumes open_set only arrives while no row is open.
module fpm_row_track #(
    parameter int ROW_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_set,
    input  logic             open_clr,
    input  logic [ROW_W-1:0] new_row,
    input  logic [ROW_W-1:0] cmp_row,
    output logic             hit
);

    logic             open_vld;
    logic [ROW_W-1:0] open_row;

    // Record the row on opening, forget it on closing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_vld <= 1'b0;
            open_row <= '0;
        end else if (open_set) begin
            open_vld <= 1'b1;
            open_row <= new_row;
        end else if (open_clr) begin
            open_vld <= 1'b0;
        end
    end

    assign hit = open_vld && (cmp_row == open_row);

    // R7: a new row is only opened after the previous one was closed.
    a_r7_open_only_when_closed: assert property (@(posedge clk) disable iff (!rst_n)
        open_set |-> !open_vld);

endmodule

// File: rtl/fpm_dram_ctrl.sv
// Page-mode controller for an x4 multiplexed-address DRAM.
// Accepts one host request at a time, keeps the row open, issues
// column-only cycles on row hits, and closes/precharges on misses,
// on refresh requests and before the row-low limit. Writes use
// early-write timing. Assumes T_RCD_NS > T_RAH_NS and that the row-low
// maximum is far larger than one access.
module fpm_dram_ctrl
    import fpm_pkg::*;
#(
    parameter int CLK_NS      = 4,
    parameter int T_RP_NS     = 50,
    parameter int T_RAS_NS    = 70,
    parameter int T_RC_NS     = 130,
    parameter int T_RCD_NS    = 20,
    parameter int T_RAH_NS    = 10,
    parameter int T_CAS_NS    = 20,
    parameter int T_CAC_NS    = 20,
    parameter int T_CP_NS     = 10,
    parameter int T_PC_NS     = 40,
    parameter int T_RAC_NS    = 70,
    parameter int T_RASMAX_NS = 100000,
    parameter int ADDR_W      = 10,
    parameter int DATA_W      = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [2*ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_rdata,
    input  logic                ref_req,
    output logic                ref_gnt,
    output logic [ADDR_W-1:0]   dram_addr,
    output logic                dram_ras_n,
    output logic                dram_cas_n,
    output logic                dram_we_n,
    output logic                dram_oe_n,
    output logic [DATA_W-1:0]   dq_out,
    output logic                dq_oe,
    input  logic [DATA_W-1:0]   dq_in
);

    // Timing figures in clock cycles.
    localparam int T_RP     = ns_to_cyc_up(T_RP_NS, CLK_NS);
    localparam int T_RAS    = ns_to_cyc_up(T_RAS_NS, CLK_NS);
    localparam int T_RC     = ns_to_cyc_up(T_RC_NS, CLK_NS);
    localparam int T_RCD    = ns_to_cyc_up(T_RCD_NS, CLK_NS);
    localparam int T_RAH    = ns_to_cyc_up(T_RAH_NS, CLK_NS);
    localparam int T_CASE   = imax(ns_to_cyc_up(T_CAS_NS, CLK_NS),
                                   ns_to_cyc_up(T_CAC_NS, CLK_NS));
    localparam int T_CP     = ns_to_cyc_up(T_CP_NS, CLK_NS);
    localparam int T_PC     = ns_to_cyc_up(T_PC_NS, CLK_NS);
    localparam int T_RAC    = ns_to_cyc_up(T_RAC_NS, CLK_NS);
    localparam int T_RASMAX = T_RASMAX_NS / CLK_NS;
    localparam int T_CPE    = imax(1, imax(T_CP, T_PC - T_CASE - 2));
    localparam int RAS_CLOSE_AT = T_RASMAX - T_CASE - T_RAC - T_CPE - 8;
    localparam int REF_BOUND = T_RCD + T_CASE + T_RAC + T_CPE + T_RAS + T_RC + T_RP + 8;

    localparam int ST_MAX = imax(T_RCD, imax(T_CASE, T_CPE));
    localparam int ST_W   = $clog2(ST_MAX + 1);
    localparam int RP_W   = $clog2(T_RP + 1);
    localparam int RC_W   = $clog2(T_RC + 1);
    localparam int AW     = $clog2(T_RASMAX + 1);
    localparam int RW     = $clog2(REF_BOUND + 2);

    localparam logic [AW-1:0] AGE_RAH    = AW'(T_RAH);
    localparam logic [AW-1:0] AGE_RAC_M1 = AW'(T_RAC - 1);
    localparam logic [AW-1:0] AGE_RAS_M1 = AW'(T_RAS - 1);
    localparam logic [AW-1:0] AGE_CLOSE  = AW'(RAS_CLOSE_AT);
    localparam logic [AW-1:0] AGE_MAX_M1 = AW'(T_RASMAX - 1);
    localparam logic [AW-1:0] AGE_SAT    = AW'(T_RASMAX);

    fpm_state_e state, nxt;

    logic [ADDR_W-1:0] cur_row, cur_col;
    logic              cur_wr;
    logic [DATA_W-1:0] cur_wd;
    logic [AW-1:0]     ras_age;
    logic              ras_old;

    logic              st_load, rp_load, rc_load;
    logic [ST_W-1:0]   st_val;
    logic              st_done, rp_done, rc_done;
    logic              hit, accept, open_set, close_row;
    logic              row_low, read_done;

    // Per-state timing counter, plus precharge and row-cycle counters.
    fpm_timer #(.MAXV(ST_MAX)) u_st_tmr (
        .clk(clk), .rst_n(rst_n), .load(st_load), .load_val(st_val), .done(st_done));

    fpm_timer #(.MAXV(T_RP)) u_rp_tmr (
        .clk(clk), .rst_n(rst_n), .load(rp_load),
        .load_val(RP_W'(T_RP - 1)), .done(rp_done));

    fpm_timer #(.MAXV(T_RC)) u_rc_tmr (
        .clk(clk), .rst_n(rst_n), .load(rc_load),
        .load_val(RC_W'(T_RC - 1)), .done(rc_done));

    fpm_row_track #(.ROW_W(ADDR_W)) u_row (
        .clk(clk), .rst_n(rst_n), .open_set(open_set), .open_clr(close_row),
        .new_row(req_addr[2*ADDR_W-1:ADDR_W]),
        .cmp_row(req_addr[2*ADDR_W-1:ADDR_W]), .hit(hit));

    assign ras_old   = (ras_age >= AGE_CLOSE);
    assign read_done = cur_wr || (ras_age >= AGE_RAC_M1);

    // Host may be accepted from closed idle or on a row hit in an open page.
    always_comb begin
        req_ready = 1'b0;
        if (!ref_req) begin
            if (state == ST_IDLE)
                req_ready = rp_done && rc_done;
            else if (state == ST_OPEN)
                req_ready = hit && !ras_old;
        end
    end
    assign accept = req_valid && req_ready;

    // Next-state and timer-load decode.
    always_comb begin
        nxt       = state;
        st_load   = 1'b0;
        st_val    = '0;
        rp_load   = 1'b0;
        rc_load   = 1'b0;
        open_set  = 1'b0;
        close_row = 1'b0;
        case (state)
            ST_IDLE: begin
                if (rp_done && rc_done) begin
                    if (ref_req) begin
                        nxt = ST_REF;
                    end else if (req_valid) begin
                        nxt      = ST_ROW;
                        open_set = 1'b1;
                        rc_load  = 1'b1;
                        st_load  = 1'b1;
                        st_val   = ST_W'(T_RCD - 1);
                    end
                end
            end
            ST_ROW: begin
                if (st_done) begin
                    nxt     = ST_CAS;
                    st_load = 1'b1;
                    st_val  = ST_W'(T_CASE - 1);
                end
            end
            ST_COLSET: begin
                nxt     = ST_CAS;
                st_load = 1'b1;
                st_val  = ST_W'(T_CASE - 1);
            end
            ST_CAS: begin
                if (st_done && read_done) begin
                    nxt     = ST_CP;
                    st_load = 1'b1;
                    st_val  = ST_W'(T_CPE - 1);
                end
            end
            ST_CP: begin
                if (st_done) nxt = ST_OPEN;
            end
            ST_OPEN: begin
                if (ref_req || ras_old || (req_valid && !hit))
                    nxt = ST_CLOSE;
                else if (req_valid)
                    nxt = ST_COLSET;
            end
            ST_CLOSE: begin
                if (ras_age >= AGE_RAS_M1) begin
                    nxt       = ST_IDLE;
                    rp_load   = 1'b1;
                    close_row = 1'b1;
                end
            end
            ST_REF: begin
                if (!ref_req) begin
                    nxt     = ST_IDLE;
                    rp_load = 1'b1;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Capture the accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_row <= '0;
            cur_col <= '0;
            cur_wr  <= 1'b0;
            cur_wd  <= '0;
        end else if (accept) begin
            cur_row <= req_addr[2*ADDR_W-1:ADDR_W];
            cur_col <= req_addr[ADDR_W-1:0];
            cur_wr  <= req_write;
            cur_wd  <= req_wdata;
        end
    end

    assign row_low = (state != ST_IDLE) && (state != ST_REF);

    // Cycles since the row strobe fell, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ras_age <= '0;
        else if (state == ST_IDLE && nxt == ST_ROW)
            ras_age <= '0;
        else if (row_low && ras_age != AGE_SAT)
            ras_age <= ras_age + 1'b1;
    end

    // Capture read data at the end of the column strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= (state == ST_CAS) && (nxt == ST_CP) && !cur_wr;
            if ((state == ST_CAS) && (nxt == ST_CP) && !cur_wr)
                rsp_rdata <= dq_in;
        end
    end

    // Strobe, address and bus decode from the registered state.
    always_comb begin
        dram_ras_n = !row_low;
        dram_cas_n = (state != ST_CAS);
        dram_we_n  = !(cur_wr && (state == ST_ROW || state == ST_COLSET || state == ST_CAS));
        dram_oe_n  = !(!cur_wr && state == ST_CAS);
        dq_oe      = cur_wr && (state == ST_ROW || state == ST_COLSET || state == ST_CAS);
        dq_out     = cur_wd;
        ref_gnt    = (state == ST_REF);
        if (state == ST_IDLE || state == ST_REF || (state == ST_ROW && ras_age < AGE_RAH))
            dram_addr = cur_row;
        else
            dram_addr = cur_col;
    end

    // Checker state: cycles refresh has waited for its grant.
    logic [RW-1:0] ref_wait;
    always_ff @(posedge clk) begin
        if (!rst_n)                  ref_wait <= '0;
        else if (ref_req && !ref_gnt) ref_wait <= (ref_wait == '1) ? ref_wait : ref_wait + 1'b1;
        else                          ref_wait <= '0;
    end

    // R6: column strobe only inside an open row.
    a_r6_cas_within_ras: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_cas_n |-> !dram_ras_n);

    // R12: never drive the bus while the DRAM may drive it.
    a_r12_no_bus_fight: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (!dram_we_n && dram_oe_n));

    // R4: write enable is already low when the column strobe falls.
    a_r4_early_we: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_cas_n) && !dram_we_n) |-> $past(!dram_we_n));

    // R3: column address holds while the column strobe is low.
    a_r3_col_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!dram_cas_n && $past(!dram_cas_n)) |-> $stable(dram_addr));

    // R8: row strobe low for at least the row-low minimum.
    a_r8_ras_min: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_ras_n) |-> ($past(ras_age) >= AGE_RAS_M1));

    // R10: row strobe never exceeds its maximum low time.
    a_r10_ras_max: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_ras_n |-> (ras_age <= AGE_MAX_M1));

    // R11: granted device has its strobes released and bus undriven.
    a_r11_gnt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ref_gnt |-> (dram_ras_n && dram_cas_n && !dq_oe && !req_ready));

    // R11: refresh waits a bounded number of cycles.
    a_r11_gnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ref_wait <= RW'(REF_BOUND));

    // R5: read response is a single-cycle pulse.
    a_r5_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

endmodule

// File: tb/fpm_dram_ctrl_bench.sv
// Self-checking bench: behavioural DRAM model with timing monitors,
// write/read sweeps over rows and columns, row-limit and refresh scenarios.
module fpm_dram_ctrl_bench;

    localparam int CLK = 4;
    // Cycle values computed here by ceiling division at a 4 ns clock.
    localparam int C_RP = 13, C_RAS = 18, C_RC = 33, C_RCD = 5, C_RAH = 3;
    localparam int C_CAS = 5, C_CAC = 5, C_CP = 3, C_PC = 10, C_RAC = 18;
    localparam int C_RASMAX = 160;
    localparam int BOUND = C_RCD + C_CAS + C_RAC + C_CP + C_RAS + C_RC + C_RP + 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, ref_req = 1'b0;
    logic [19:0] req_addr = '0;
    logic [3:0]  req_wdata = '0;
    logic        req_ready, rsp_valid, ref_gnt;
    logic [3:0]  rsp_rdata, dq_out, dq_in;
    logic [9:0]  dram_addr;
    logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dq_oe;

    always #(CLK/2) clk = ~clk;

    fpm_dram_ctrl #(.CLK_NS(CLK), .T_RASMAX_NS(C_RASMAX * CLK)) u_fpm_dram_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ref_req(ref_req), .ref_gnt(ref_gnt),
        .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
        .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dq_out(dq_out), .dq_oe(dq_oe),
        .dq_in(dq_in));

    int errors = 0;
    int checks = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] dflt(input logic [19:0] a);
        return a[3:0] ^ a[13:10] ^ 4'h5;
    endfunction

    logic [3:0] mem [logic [19:0]];
    logic [3:0] sb  [logic [19:0]];
    logic [3:0] exp_q [$];
    logic [19:0] exp_addr = '0;
    logic [3:0]  exp_wd = '0;

    function automatic logic [3:0] mem_rd(input logic [19:0] a);
        return mem.exists(a) ? mem[a] : dflt(a);
    endfunction
    function automatic logic [3:0] sb_rd(input logic [19:0] a);
        return sb.exists(a) ? sb[a] : dflt(a);
    endfunction

    // DRAM model and timing monitor, sampled between clock edges.
    int ras_low = 0, ras_high = 1000, cas_low = 0, cas_high = 1000;
    int cyc = 0, last_ras_fall = -1000, last_cas_fall = -1000, ras_falls = 0;
    bit prev_ras = 1'b1, prev_cas = 1'b1, prev_we = 1'b1, first_cas = 1'b1;
    logic [9:0] row_l = '0, col_l = '0;

    always @(negedge clk) begin
        if (!rst_n) begin
            dq_in = 4'h0;
        end else begin
            cyc++;
            if (!dram_ras_n && prev_ras) begin
                chk(ras_high >= C_RP, "R7 row precharge cycles", ras_high, C_RP);
                chk(cyc - last_ras_fall >= C_RC, "R8 row cycle period", cyc - last_ras_fall, C_RC);
                chk(dram_addr == exp_addr[19:10], "R2 row address at row strobe", dram_addr, exp_addr[19:10]);
                row_l = dram_addr; last_ras_fall = cyc; ras_low = 1; first_cas = 1'b1; ras_falls++;
            end else if (!dram_ras_n) begin
                ras_low++;
                if (ras_low <= C_RAH)
                    chk(dram_addr == row_l, "R2 row address hold", dram_addr, row_l);
            end
            if (dram_ras_n && !prev_ras) begin
                chk(ras_low >= C_RAS, "R8 row low minimum", ras_low, C_RAS);
                chk(ras_low <= C_RASMAX, "R10 row low maximum", ras_low, C_RASMAX);
                ras_high = 1;
            end else if (dram_ras_n) begin
                ras_high++;
            end
            if (!dram_cas_n && prev_cas) begin
                chk(!dram_ras_n, "R6 column strobe inside row", dram_ras_n, 0);
                chk(ras_low - 1 >= C_RCD, "R8 row to column delay", ras_low - 1, C_RCD);
                if (!first_cas) begin
                    chk(cas_high >= C_CP, "R8 column precharge", cas_high, C_CP);
                    chk(cyc - last_cas_fall >= C_PC, "R8 page cycle", cyc - last_cas_fall, C_PC);
                end
                col_l = dram_addr;
                chk({row_l, col_l} == exp_addr, "R3 column address at column strobe", {row_l, col_l}, exp_addr);
                if (!dram_we_n) begin
                    chk(!prev_we, "R4 write enable before column strobe", prev_we, 0);
                    chk(dq_oe && dram_oe_n && dq_out == exp_wd, "R4 write data driven", dq_out, exp_wd);
                    mem[{row_l, col_l}] = dq_out;
                end
                first_cas = 1'b0; last_cas_fall = cyc; cas_low = 1;
            end else if (!dram_cas_n) begin
                cas_low++;
                chk(dram_addr == col_l, "R3 column address hold", dram_addr, col_l);
            end
            if (dram_cas_n && !prev_cas) begin
                chk(cas_low >= C_CAS, "R8 column low minimum", cas_low, C_CAS);
                cas_high = 1;
            end else if (dram_cas_n) begin
                cas_high++;
            end
            if (dq_oe || !dram_oe_n)
                chk(!(dq_oe && !dram_oe_n) && (dq_oe ? !dram_we_n : !dram_cas_n),
                    "R12 bus direction", dq_oe, !dram_oe_n);
            if (ref_gnt)
                chk(dram_ras_n && dram_cas_n, "R11 strobes released under grant", dram_ras_n, 1);
            // Drive valid data only once both access times have elapsed (R9).
            if (!dram_ras_n && !dram_cas_n && dram_we_n && !dram_oe_n
                && cas_low >= C_CAC && ras_low >= C_RAC)
                dq_in = mem_rd({row_l, col_l});
            else
                dq_in = ~mem_rd({row_l, col_l});
            if (rsp_valid) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5 unexpected response", 1, 0);
                end else begin
                    logic [3:0] e;
                    e = exp_q.pop_front();
                    chk(rsp_rdata == e, "R5 R9 read data", rsp_rdata, e);
                end
            end
            prev_ras = dram_ras_n; prev_cas = dram_cas_n; prev_we = dram_we_n;
        end
    end

    task automatic do_req(input bit wr, input logic [19:0] a, input logic [3:0] d);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        while (1) begin
            #1;
            if (req_ready) break;
            @(negedge clk);
        end
        exp_addr = a; exp_wd = d;
        if (wr) sb[a] = d;
        else    exp_q.push_back(sb_rd(a));
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_up();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_up();
    end

    function automatic logic [19:0] sweep_addr(input int r, input int c);
        return {10'(r * 37 + 5), 10'(c * 3 + r)};
    endfunction

    initial begin
        int base;
        int n;
        repeat (4) @(negedge clk);
        // R1: reset state at the ports.
        chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1 strobes high in reset", 0, 1);
        chk(!dq_oe && !ref_gnt && !rsp_valid, "R1 bus, grant and response low in reset", dq_oe, 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk(dram_ras_n && dram_cas_n && !dq_oe, "R1 idle after reset", dram_ras_n, 1);

        // R4 R6: page bursts of writes, one row opening per row.
        base = ras_falls;
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 8; c++)
                do_req(1'b1, sweep_addr(r, c), 4'((r * 8 + c) * 5 + 3));
        repeat (10) @(negedge clk);
        chk(ras_falls - base == 4, "R6 page hits open each row once", ras_falls - base, 4);

        // R7: reads alternating rows, every one a miss.
        base = ras_falls;
        for (int c = 0; c < 8; c++)
            for (int r = 0; r < 4; r++)
                do_req(1'b0, sweep_addr(r, c), 4'h0);
        drain();
        chk(ras_falls - base == 32, "R7 each row change reopens", ras_falls - base, 32);

        // R5 R6: reads in row order, page hits.
        base = ras_falls;
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 8; c++)
                do_req(1'b0, sweep_addr(r, c), 4'h0);
        drain();
        chk(ras_falls - base == 4, "R6 page read hits", ras_falls - base, 4);

        // R5: cells never written return their default content.
        for (int k = 0; k < 6; k++)
            do_req(1'b0, {10'(900 + k), 10'(17 * k)}, 4'h0);
        drain();

        // R10: a long run of hits forces the row closed and reopened.
        base = ras_falls;
        for (int k = 0; k < 30; k++)
            do_req(1'b0, sweep_addr(1, k % 8), 4'h0);
        drain();
        chk(ras_falls - base >= 3, "R10 long page closed and reopened", ras_falls - base, 3);

        // R11: refresh while a row is open and a read is in flight.
        do_req(1'b0, sweep_addr(2, 1), 4'h0);
        ref_req = 1'b1;
        n = 0;
        while (!ref_gnt && n <= BOUND + 2) begin @(negedge clk); n++; end
        chk(ref_gnt && n <= BOUND, "R11 grant within bound", n, BOUND);
        req_valid = 1'b1; req_write = 1'b1; req_addr = sweep_addr(3, 2); req_wdata = 4'hA;
        for (int k = 0; k < 10; k++) begin
            #1;
            chk(!req_ready && dram_ras_n && dram_cas_n, "R11 request ignored under grant", req_ready, 0);
            @(negedge clk);
        end
        ref_req = 1'b0;
        do_req(1'b1, sweep_addr(3, 2), 4'hA);
        do_req(1'b0, sweep_addr(3, 2), 4'h0);
        drain();

        // R11: refresh from a closed, idle device.
        repeat (C_RASMAX + 20) @(negedge clk);
        ref_req = 1'b1;
        n = 0;
        while (!ref_gnt && n <= BOUND + 2) begin @(negedge clk); n++; end
        chk(ref_gnt && n <= BOUND, "R11 grant from idle", n, BOUND);
        ref_req = 1'b0;
        do_req(1'b0, sweep_addr(0, 0), 4'h0);
        drain();
        chk(exp_q.size() == 0, "R5 all responses returned", exp_q.size(), 0);

        finish_up();
    end

endmodule